// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host reach an asynchronous static memory that is 16 bits wide and has one select per byte. The host raises `req` with a word address, a write flag, two byte-enable bits and write data. The controller then drives the memory's active-low chip select, output enable, write strobe and byte selects. It holds the address and data steady for as many clocks as the memory's timing limits need. It ends each transfer with a one-clock `done` pulse, and returns the read word on `rdata`.

All wait lengths are worked out at elaboration from the clock period and the memory's timing figures. Each figure is rounded up to whole clocks. For a read, the access length sets how many clocks chip select and output enable stay low. For a write, the address lead time, the strobe width, the bus-release delay and the data setup time together set the write window. Output enable stays high for the whole of a write. The controller's data drivers switch on only once the memory has had time to release the bus after the strobe falls. They switch off one clock after the strobe rises.

The state machine has five states. **IDLE** waits for a request. **READ** holds chip select and output enable low for the access length. **WRITE** holds the write window. **WHOLD** is one clock with every enable inactive while the drivers stay on. **GAP** is one clock with every enable inactive; `done` pulses in it. The transitions are:
- IDLE or GAP goes to READ or WRITE when a request is taken, and otherwise to IDLE.
- READ goes to GAP after its last wait clock.
- WRITE goes to WHOLD after its last window clock.
- WHOLD always goes to GAP.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and on the first clock after it, `ready` is 1, `done` is 0, all five memory controls are 1 (inactive) and `sram_dq_oe` is 0.
- R2: A request is taken on a rising edge where `req` and `ready` are both 1, and the cycle starts on the next clock. `ready` is 1 only in IDLE and GAP. A `req` seen while `ready` is 0 has no effect: no cycle starts and memory contents are unchanged.
- R3: A read holds `sram_ce_n` and `sram_oe_n` low, with `sram_we_n` high, for exactly RD = ceil(T_ACC_NS/CLK_PERIOD_NS) clocks. `rdata` takes `sram_dq_in` at the edge that ends the last of those clocks and holds it until the next read.
- R4: A write holds `sram_ce_n` low for WT = max(ceil(T_AW_NS/P), WL) clocks, where P is the clock period and WL = max(ceil(T_WP_NS/P), ceil(T_WHZ_NS/P) + ceil(T_DS_NS/P)). `sram_we_n` is low for the last WL of those clocks. `sram_oe_n` stays high for the whole write.
- R5: `sram_dq_oe` is 0 from the start of the write until ceil(T_WHZ_NS/P) clocks after `sram_we_n` falls. It is then 1 through the WHOLD clock in which `sram_we_n` is already high, and 0 again on the next clock. It is never 1 while `sram_oe_n` is 0.
- R6: During a read or write, `sram_lb_n` is low only if `req_be[0]` was set at acceptance, and `sram_ub_n` is low only if `req_be[1]` was set. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A write with one enable changes only that byte of the word.
- R7: A write ends with one WHOLD clock in which every memory control is inactive, followed by GAP.
- R8: Every cycle ends with one GAP clock with all controls inactive. `done` is 1 in that clock and for only that clock. `ready` is 1 in GAP, so a request held high is taken there, leaving exactly one idle clock between back-to-back cycles.
- R9: `sram_addr` stays unchanged while `sram_ce_n` is low. `sram_dq_out` carries the write word whenever `sram_dq_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_be | input | 2 | Byte enables (bit 0 low byte) |
| req_wdata | input | 16 | Write word |
| ready | output | 1 | Request can be taken this clock |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Last read word |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_ub_n | output | 1 | Upper byte select, active low |
| sram_lb_n | output | 1 | Lower byte select, active low |
| sram_addr | output | 17 | Memory address |
| sram_dq_out | output | 16 | Write data to the bus |
| sram_dq_oe | output | 1 | Bus driver enable |
| sram_dq_in | input | 16 | Read data from the bus |

## Verification
The bench builds the controller with a 10 ns period and the figures of the fastest grade: 55 ns access, 45 ns strobe, 50 ns address lead, 25 ns data setup and 30 ns release. The access time rounds up to six clocks, which exercises the ceiling division. The write window is then set by release plus setup rather than by the strobe width, and the address lead is no longer than the strobe. As a result the strobe falls on the first write clock. The bench's memory model returns garbage until the read address has been stable for the full access length, so a capture one clock early is caught.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_WHOLD = 3'd3,
        ST_GAP   = 3'd4
    } sram_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] elapsed
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (clr) begin
            elapsed <= '0;
        end else if (elapsed != CNT_TOP) begin
            elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              cap,
    input  logic [DATA_W-1:0] cap_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BE_W-1:0]   be_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= in_addr;
            be_q    <= in_be;
            wdata_q <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cap) begin
            rdata_q <= cap_data;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ACC_NS      = 70,
    parameter int T_WP_NS       = 60,
    parameter int T_AW_NS       = 65,
    parameter int T_DS_NS       = 30,
    parameter int T_WHZ_NS      = 30,
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int RD_CYC   = ceil_div(T_ACC_NS, CLK_PERIOD_NS);
    localparam int AW_CYC   = ceil_div(T_AW_NS, CLK_PERIOD_NS);
    localparam int WP_CYC   = ceil_div(T_WP_NS, CLK_PERIOD_NS);
    localparam int HZ_CYC   = ceil_div(T_WHZ_NS, CLK_PERIOD_NS);
    localparam int DS_CYC   = ceil_div(T_DS_NS, CLK_PERIOD_NS);
    localparam int WL_CYC   = max2(WP_CYC, HZ_CYC + DS_CYC);
    localparam int WT_CYC   = max2(AW_CYC, WL_CYC);
    localparam int MAX_CYC  = max2(RD_CYC, WT_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WT_CYC - 1);
    localparam logic [CNT_W-1:0] WE_START  = CNT_W'(WT_CYC - WL_CYC);
    localparam logic [CNT_W-1:0] DRV_START = CNT_W'(WT_CYC - WL_CYC + HZ_CYC);

    if (RD_CYC < 1 || WP_CYC < 1 || DS_CYC < 1) begin : g_bad_timing
        $error("sram_async_ctrl: a derived wait count is below one clock");
    end

    sram_state_e      state_q, state_d;
    logic [CNT_W-1:0] elapsed;
    logic             accept;
    logic             rd_last, wr_last, cap;
    logic             active;
    logic [1:0]       be_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign accept  = req && ready;
    assign rd_last = (state_q == ST_READ)  && (elapsed == RD_LAST);
    assign wr_last = (state_q == ST_WRITE) && (elapsed == WR_LAST);
    assign cap     = rd_last;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_d != state_q),
        .elapsed (elapsed)
    );

    sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(2)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .in_addr  (req_addr),
        .in_be    (req_be),
        .in_wdata (req_wdata),
        .cap      (cap),
        .cap_data (sram_dq_in),
        .addr_q   (addr_q),
        .be_q     (be_q),
        .wdata_q  (wdata_q),
        .rdata_q  (rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_GAP: begin
                if (accept) begin
                    state_d = req_write ? ST_WRITE : ST_READ;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_READ:  if (rd_last) state_d = ST_GAP;
            ST_WRITE: if (wr_last) state_d = ST_WHOLD;
            ST_WHOLD: state_d = ST_GAP;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        active     = (state_q == ST_READ) || (state_q == ST_WRITE);
        ready      = (state_q == ST_IDLE) || (state_q == ST_GAP);
        done       = (state_q == ST_GAP);
        sram_ce_n  = !active;
        sram_oe_n  = (state_q != ST_READ);
        sram_we_n  = !((state_q == ST_WRITE) && (elapsed >= WE_START));
        sram_ub_n  = !(active && be_q[1]);
        sram_lb_n  = !(active && be_q[0]);
        sram_dq_oe = ((state_q == ST_WRITE) && (elapsed >= DRV_START)) ||
                     (state_q == ST_WHOLD);
        sram_addr   = addr_q;
        sram_dq_out = wdata_q;
    end

    // R5
    drv_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);
    // R5
    drv_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> !sram_dq_oe);
    // R5
    drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe);
    // R5
    drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |=> !sram_dq_oe);
    // R4
    oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);
    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
    localparam int P   = 10;
    localparam int ACC = 55, WP = 45, AW = 50, DS = 25, WHZ = 30;
    localparam int RD  = (ACC + P - 1) / P;
    localparam int AWC = (AW + P - 1) / P;
    localparam int WPC = (WP + P - 1) / P;
    localparam int HZC = (WHZ + P - 1) / P;
    localparam int DSC = (DS + P - 1) / P;
    localparam int WL  = (WPC > HZC + DSC) ? WPC : HZC + DSC;
    localparam int WT  = (AWC > WL) ? AWC : WL;

    logic clk = 0, rst_n = 0;
    logic req = 0, req_write = 0;
    logic [16:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic ready, done;
    logic [15:0] rdata;
    logic ce_n, oe_n, we_n, ub_n, lb_n, dq_oe;
    logic [16:0] s_addr;
    logic [15:0] dq_out;
    logic [15:0] dq_in = 16'h0BAD;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .CLK_PERIOD_NS(P), .T_ACC_NS(ACC), .T_WP_NS(WP), .T_AW_NS(AW),
        .T_DS_NS(DS), .T_WHZ_NS(WHZ), .ADDR_W(17), .DATA_W(16)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .ready(ready), .done(done), .rdata(rdata),
        .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
        .sram_ub_n(ub_n), .sram_lb_n(lb_n), .sram_addr(s_addr),
        .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural memory
    logic [15:0] mem [int];
    function automatic logic [15:0] rd_mem(input int a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    // Reference model: phase 0 idle, 1 read, 2 write, 3 hold, 4 gap
    int m_phase = 0, m_el = 0;
    logic m_wr = 0;
    logic [16:0] m_addr = '0;
    logic [1:0]  m_be = '0;
    logic [15:0] m_wdata = '0, m_rdata = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_el = 0; m_addr = '0; m_be = '0; m_wdata = '0; m_rdata = '0;
        end else begin
            case (m_phase)
                0, 4: begin
                    if (req) begin
                        m_phase = req_write ? 2 : 1; m_el = 0;
                        m_addr = req_addr; m_be = req_be; m_wdata = req_wdata;
                    end else m_phase = 0;
                end
                1: if (m_el == RD - 1) begin m_rdata = rd_mem(int'(m_addr)); m_phase = 4; end
                   else m_el++;
                2: if (m_el == WT - 1) m_phase = 3; else m_el++;
                3: m_phase = 4;
                default: m_phase = 0;
            endcase
        end
    end

    // Memory device model and per-clock comparison
    logic p_we = 1, p_drv = 0, p_ub = 1, p_lb = 1;
    logic [16:0] p_addr = '0, rd_addr = '0;
    logic [15:0] p_data = '0;
    int stab = 0;

    always @(negedge clk) begin
        bit act, e_we, e_drv;
        // write commit at the rising strobe
        if (rst_n && !p_we && we_n && p_drv) begin
            logic [15:0] w;
            w = rd_mem(int'(p_addr));
            if (!p_lb) w[7:0]  = p_data[7:0];
            if (!p_ub) w[15:8] = p_data[15:8];
            mem[int'(p_addr)] = w;
        end
        p_we = we_n; p_drv = dq_oe; p_ub = ub_n; p_lb = lb_n;
        p_addr = s_addr; p_data = dq_out;
        // read data becomes valid only after the full access time
        if (!ce_n && !oe_n && we_n) begin
            stab = (stab > 0 && s_addr == rd_addr) ? stab + 1 : 1;
            rd_addr = s_addr;
        end else stab = 0;
        dq_in = (stab >= RD) ? rd_mem(int'(s_addr)) : 16'h0BAD;

        if (rst_n) begin
            act   = (m_phase == 1) || (m_phase == 2);
            e_we  = !((m_phase == 2) && (m_el >= WT - WL));
            e_drv = ((m_phase == 2) && (m_el >= WT - WL + HZC)) || (m_phase == 3);
            check(ready == ((m_phase == 0) || (m_phase == 4)), "R2 ready", ready, (m_phase == 0) || (m_phase == 4));
            check(done == (m_phase == 4), "R8 done", done, m_phase == 4);
            check(ce_n == !act, "R3 ce_n", ce_n, !act);
            check(oe_n == (m_phase != 1), "R4 oe_n", oe_n, m_phase != 1);
            check(we_n == e_we, "R4 we_n", we_n, e_we);
            check(ub_n == !(act && m_be[1]), "R6 ub_n", ub_n, !(act && m_be[1]));
            check(lb_n == !(act && m_be[0]), "R6 lb_n", lb_n, !(act && m_be[0]));
            check(dq_oe == e_drv, "R5 dq_oe", dq_oe, e_drv);
            check(rdata == m_rdata, "R3 rdata", rdata, m_rdata);
            if (act) check(s_addr == m_addr, "R9 addr", s_addr, m_addr);
            if (e_drv) check(dq_out == m_wdata, "R9 wdata", dq_out, m_wdata);
            if (m_phase == 3) check(ce_n && ub_n && lb_n && oe_n && we_n, "R7 hold idle", {ce_n, ub_n, lb_n, oe_n, we_n}, 5'h1f);
        end
    end

    task automatic op(input bit wr, input logic [16:0] a, input logic [1:0] be,
                      input logic [15:0] d);
        @(negedge clk);
        req = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 0;
        while (!done) @(negedge clk);
    endtask

    task automatic read_expect(input logic [16:0] a, input logic [15:0] e, input string tag);
        op(0, a, 2'b11, 16'h0);
        check(rdata == e, tag, rdata, e);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: got %0d expected below 100000", wd);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while held
        check(ready && !done && ce_n && oe_n && we_n && ub_n && lb_n && !dq_oe,
              "R1 reset", {ready, done, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe}, 8'hBE);
        rst_n = 1;
        @(negedge clk);
        check(ready && !done && ce_n && !dq_oe, "R1 after reset",
              {ready, done, ce_n, dq_oe}, 4'hA);

        op(1, 17'd5, 2'b11, 16'hA1B2);
        read_expect(17'd5, 16'hA1B2, "R3 full read");
        op(1, 17'd5, 2'b01, 16'hFFCC);
        read_expect(17'd5, 16'hA1CC, "R6 lower only");
        op(1, 17'd5, 2'b10, 16'h77EE);
        read_expect(17'd5, 16'h77CC, "R6 upper only");
        op(1, 17'h1FFFF, 2'b11, 16'h8001);
        read_expect(17'h1FFFF, 16'h8001, "R3 top address");

        // R2: a request during a busy read is ignored
        op(1, 17'd9, 2'b11, 16'h1234);
        @(negedge clk);
        req = 1; req_write = 0; req_addr = 17'd9; req_be = 2'b11;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 0;
        repeat (2) @(negedge clk);
        req = 1; req_write = 1; req_addr = 17'd9; req_wdata = 16'h0000;
        @(negedge clk);
        check(!ready, "R2 busy", ready, 1'b0);
        req = 0;
        while (!done) @(negedge clk);
        check(rdata == 16'h1234, "R2 read in flight", rdata, 16'h1234);
        read_expect(17'd9, 16'h1234, "R2 ignored write");

        // R8: back-to-back writes with req held high
        @(negedge clk);
        req = 1; req_write = 1; req_addr = 17'd20; req_be = 2'b11; req_wdata = 16'h5555;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req_addr = 17'd21; req_wdata = 16'h6666;
        while (!done) @(negedge clk);
        check(ready, "R8 ready in gap", ready, 1'b1);
        @(negedge clk);
        req = 0;
        check(!ce_n && !ready, "R8 next cycle starts", {ce_n, ready}, 2'b00);
        while (!done) @(negedge clk);
        read_expect(17'd20, 16'h5555, "R8 first of pair");
        read_expect(17'd21, 16'h6666, "R8 second of pair");

        // R6: read with no byte enables still completes
        op(0, 17'd21, 2'b00, 16'h0);
        check(rdata == 16'h6666, "R6 no enables read", rdata, 16'h6666);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule